// File: doc/BRIEF.md
# Memory Decoder Commit Register Bank

This block holds a bank of programmable host-address decoder register sets. Software reaches them through a simple 32-bit word-addressed read/write port. Each set has a 64-bit base, a 64-bit size, a control word and a 64-bit auxiliary field. In the switch flavour the auxiliary field holds eight byte-wide downstream port IDs. In the endpoint flavour it holds a skip amount. A read-only capability word reports how many decoders there are, the target count, and which optional address-bit groups may steer interleave selection.

Software programs a decoder and then sets its commit bit. A small sequencer for that decoder then waits a configurable number of validation cycles. After that wait it sets exactly one of two status bits, committed or commit-error. It checks the commit order, a non-zero size, a supported interleave-ways code, the target limit (switch flavour) and even division of the size by the ways (endpoint flavour).

Once a decoder is committed, its programming is frozen. Decoders must be taken down from the highest committed index downward, and a locked decoder cannot be taken down.

Address map: word address 0 is the capability word. Decoder i occupies word addresses 8*(i+1) to 8*(i+1)+7, with these field offsets:
- 0: base low
- 1: base high
- 2: size low
- 3: size high
- 4: control
- 5: auxiliary low
- 6: auxiliary high
- 7: reads as zero

Top module: `mdec_bank`

## Requirements
- R1: After reset every decoder register reads zero. The capability word reads {14'b0, high-bits flag [17], low-bits flag [16], target count [15:8], decoder count [7:0]}.
- R2: Base, size and auxiliary halves read back what was last written at offsets 0/1, 2/3 and 5/6 while the decoder is neither committed nor validating. A switch target list keeps entry k in bits 8k+7:8k of the 64-bit auxiliary field.
- R3: The control word has these bits:
  - commit request [0]
  - committed [1], read-only
  - commit-error [2], read-only
  - lock [3]
  - target type [4]
  - ways code [11:8]
  - granularity code [15:12]
  Writing bits 1 and 2 has no effect.
- R4: Decoder i>0 only reaches committed if decoder i-1 is committed when validation ends; otherwise commit-error is set.
- R5: After the write that sets commit (rising from 0), both status bits stay clear for VALIDATE_CYCLES-1 further cycles. Exactly one of them is set after VALIDATE_CYCLES cycles.
- R6: A commit with size zero ends in commit-error.
- R7: Ways codes 0,1,2,3,8,9 mean 1,2,4,8,3,6 ways; any other code ends in commit-error. In the switch flavour a ways count above the target count also ends in commit-error.
- R8: In the endpoint flavour a size that is not an exact multiple of the ways count ends in commit-error.
- R9: While a decoder is committed, writes to its base, size, auxiliary field and its type, ways and granularity fields are ignored.
- R10: Clearing commit on a committed decoder un-commits it only if the next higher decoder is not committed; otherwise the write is ignored.
- R11: Clearing commit on a decoder in commit-error clears the error.
- R12: A committed decoder with lock set ignores all control writes, so it cannot be un-committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |

## Verification
The assertions watch every cycle for these properties:
- committed never rises without an accepting validation, and acceptance only happens while the lower neighbour is committed;
- the two status bits are never both set;
- validation never runs past its cycle bound, and it always ends with a status set;
- an un-commit only happens while the upper neighbour is idle.

Only the bench scenarios can show the register-level effects:
- the frozen fields really holding their values;
- the lock blocking an un-commit;
- the error clearing;
- the arithmetic of the ways and divisibility checks against randomly drawn sizes and codes;
- the target-count limit of the switch flavour.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  localparam int FLD_BASE_LO = 0;
  localparam int FLD_BASE_HI = 1;
  localparam int FLD_SIZE_LO = 2;
  localparam int FLD_SIZE_HI = 3;
  localparam int FLD_CTRL    = 4;
  localparam int FLD_AUX_LO  = 5;
  localparam int FLD_AUX_HI  = 6;

  typedef enum logic {SQ_IDLE, SQ_CHECK} seq_state_e;

  // Decoded ways count for a control-word code; 0 marks an unsupported code.
  function automatic int ways_count(input logic [3:0] code);
    case (code)
      4'd0: return 1;
      4'd1: return 2;
      4'd2: return 4;
      4'd3: return 8;
      4'd8: return 3;
      4'd9: return 6;
      default: return 0;
    endcase
  endfunction

  // Remainder of a 64-bit value by three, one bit at a time from the top.
  function automatic int rem3(input logic [63:0] v);
    int r;
    r = 0;
    for (int b = 63; b >= 0; b--) r = (2 * r + int'(v[b])) % 3;
    return r;
  endfunction

  function automatic logic size_fits(input logic [63:0] size, input int ways);
    case (ways)
      1: return 1'b1;
      2: return size[0] == 1'b0;
      4: return size[1:0] == 2'b00;
      8: return size[2:0] == 3'b000;
      3: return rem3(size) == 0;
      6: return (size[0] == 1'b0) && (rem3(size) == 0);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] cap_word(input int nd, input int tc,
                                           input int il_lo, input int il_hi);
    logic [31:0] w;
    w = '0;
    w[7:0]  = 8'(nd);
    w[15:8] = 8'(tc);
    w[16]   = (il_lo != 0);
    w[17]   = (il_hi != 0);
    return w;
  endfunction

endpackage

// File: rtl/mdec_slot.sv
module mdec_slot
  import mdec_pkg::*;
#(
  parameter int SWITCH          = 0,
  parameter int TGT_CNT         = 8,
  parameter int VALIDATE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [2:0]  fld,
  input  logic [31:0] wdata,
  input  logic        lower_done,
  input  logic        upper_done,
  output logic        done,
  output logic        errored,
  output logic        busy,
  output logic        evt_req,
  output logic        evt_ok,
  output logic        evt_err,
  output logic        evt_drop,
  output logic [31:0] rdata
);
  localparam int CNT_W = $clog2(VALIDATE_CYCLES + 1);

  logic [63:0] base_q, size_q, aux_q;
  logic        commit_q, lock_q, type_q, done_q, err_q;
  logic [3:0]  ways_q, gran_q;
  logic [CNT_W-1:0] cnt_q;
  seq_state_e  st_q;

  logic frozen, ctrl_wr, err_clr, chk_end, prog_ok;
  int   ways_n;

  assign busy    = (st_q == SQ_CHECK);
  assign frozen  = done_q || busy;
  assign ctrl_wr = wr_sel && (int'(fld) == FLD_CTRL) && !(done_q && lock_q) && !busy;
  assign evt_req = ctrl_wr && wdata[0] && !commit_q;
  assign evt_drop = ctrl_wr && !wdata[0] && done_q && !upper_done;
  assign err_clr = ctrl_wr && !wdata[0] && err_q;
  assign chk_end = busy && (cnt_q == '0);

  always_comb begin
    ways_n  = ways_count(ways_q);
    prog_ok = lower_done && (size_q != '0) && (ways_n != 0);
    if (SWITCH != 0) prog_ok = prog_ok && (ways_n <= TGT_CNT);
    else             prog_ok = prog_ok && size_fits(size_q, ways_n);
  end

  assign evt_ok  = chk_end && prog_ok;
  assign evt_err = chk_end && !prog_ok;
  assign done    = done_q;
  assign errored = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else if (evt_req) begin
      st_q  <= SQ_CHECK;
      cnt_q <= CNT_W'(VALIDATE_CYCLES - 1);
    end else if (chk_end) begin
      st_q  <= SQ_IDLE;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (evt_req)                  commit_q <= 1'b1;
      else if (evt_drop || err_clr) commit_q <= 1'b0;
      if (evt_ok)        done_q <= 1'b1;
      else if (evt_drop) done_q <= 1'b0;
      if (evt_err)       err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      aux_q  <= '0;
      lock_q <= 1'b0;
      type_q <= 1'b0;
      ways_q <= '0;
      gran_q <= '0;
    end else if (wr_sel && !frozen) begin
      case (int'(fld))
        FLD_BASE_LO: base_q[31:0]  <= wdata;
        FLD_BASE_HI: base_q[63:32] <= wdata;
        FLD_SIZE_LO: size_q[31:0]  <= wdata;
        FLD_SIZE_HI: size_q[63:32] <= wdata;
        FLD_AUX_LO:  aux_q[31:0]   <= wdata;
        FLD_AUX_HI:  aux_q[63:32]  <= wdata;
        FLD_CTRL: begin
          lock_q <= wdata[3];
          type_q <= wdata[4];
          ways_q <= wdata[11:8];
          gran_q <= wdata[15:12];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (int'(fld))
      FLD_BASE_LO: rdata = base_q[31:0];
      FLD_BASE_HI: rdata = base_q[63:32];
      FLD_SIZE_LO: rdata = size_q[31:0];
      FLD_SIZE_HI: rdata = size_q[63:32];
      FLD_CTRL:    rdata = {16'b0, gran_q, ways_q, 3'b0, type_q, lock_q, err_q, done_q, commit_q};
      FLD_AUX_LO:  rdata = aux_q[31:0];
      FLD_AUX_HI:  rdata = aux_q[63:32];
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/mdec_rdmux.sv
module mdec_rdmux #(
  parameter int NUM_DEC = 4,
  parameter int BLK_W   = 5
) (
  input  logic [BLK_W-1:0]               blk,
  input  logic [2:0]                     fld,
  input  logic [31:0]                    cap,
  input  logic [NUM_DEC-1:0][31:0]       slot_rd,
  output logic [31:0]                    rdata
);
  always_comb begin
    rdata = '0;
    if (blk == '0) begin
      if (fld == 3'd0) rdata = cap;
    end else begin
      for (int i = 0; i < NUM_DEC; i++)
        if (blk == BLK_W'(i + 1)) rdata = slot_rd[i];
    end
  end
endmodule

// File: rtl/mdec_bank.sv
module mdec_bank
  import mdec_pkg::*;
#(
  parameter int NUM_DEC         = 4,
  parameter int TGT_CNT         = 8,
  parameter int SWITCH          = 0,
  parameter int VALIDATE_CYCLES = 8,
  parameter int IL_LOW          = 1,
  parameter int IL_HIGH         = 0,
  parameter int ADDR_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  localparam int BLK_W = ADDR_W - 3;
  localparam logic [31:0] CAP = cap_word(NUM_DEC, TGT_CNT, IL_LOW, IL_HIGH);

  logic [BLK_W-1:0] blk;
  logic [2:0]       fld;
  logic [NUM_DEC-1:0] dec_done, dec_err, dec_busy;
  logic [NUM_DEC-1:0] ev_req, ev_ok, ev_err, ev_drop;
  logic [NUM_DEC+1:0] done_pad;
  logic [NUM_DEC-1:0][31:0] slot_rd;

  assign blk = addr[ADDR_W-1:3];
  assign fld = addr[2:0];
  assign done_pad = {1'b0, dec_done, 1'b1};

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    mdec_slot #(
      .SWITCH(SWITCH), .TGT_CNT(TGT_CNT), .VALIDATE_CYCLES(VALIDATE_CYCLES)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(wr_en && (blk == BLK_W'(g + 1))),
      .fld(fld), .wdata(wdata),
      .lower_done(done_pad[g]), .upper_done(done_pad[g+2]),
      .done(dec_done[g]), .errored(dec_err[g]), .busy(dec_busy[g]),
      .evt_req(ev_req[g]), .evt_ok(ev_ok[g]), .evt_err(ev_err[g]),
      .evt_drop(ev_drop[g]), .rdata(slot_rd[g])
    );
  end

  mdec_rdmux #(.NUM_DEC(NUM_DEC), .BLK_W(BLK_W)) u_rdmux (
    .blk(blk), .fld(fld), .cap(CAP), .slot_rd(slot_rd), .rdata(rdata)
  );

endmodule

// File: rtl/mdec_bank_chk.sv
module mdec_bank_chk #(
  parameter int NUM_DEC = 4,
  parameter int LIMIT   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEC-1:0] committed,
  input logic [NUM_DEC-1:0] errored,
  input logic [NUM_DEC-1:0] busy,
  input logic [NUM_DEC-1:0] evt_req,
  input logic [NUM_DEC-1:0] evt_ok,
  input logic [NUM_DEC-1:0] evt_err,
  input logic [NUM_DEC-1:0] evt_drop
);
  logic [NUM_DEC+1:0] pad;
  assign pad = {1'b0, committed, 1'b1};

  for (genvar g = 0; g < NUM_DEC; g++) begin : g_chk
    logic [15:0] wait_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)          wait_cnt <= '0;
      else if (evt_req[g]) wait_cnt <= 16'd1;
      else if (busy[g])    wait_cnt <= wait_cnt + 16'd1;
      else                 wait_cnt <= '0;
    end

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ok[g] |-> pad[g]);
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(committed[g]) |-> $past(evt_ok[g]));
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(committed[g] && errored[g]));
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |-> (wait_cnt <= 16'(LIMIT)));
    p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[g]) |-> (committed[g] || errored[g]));
    p_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err[g] |=> errored[g]);
    p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_drop[g] |-> !pad[g+2]);
    p_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_drop[g] |=> !committed[g]);
  end
endmodule

bind mdec_bank mdec_bank_chk #(.NUM_DEC(NUM_DEC), .LIMIT(VALIDATE_CYCLES + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .committed(dec_done), .errored(dec_err),
  .busy(dec_busy), .evt_req(ev_req), .evt_ok(ev_ok), .evt_err(ev_err),
  .evt_drop(ev_drop)
);

// File: tb/test_mdec_bank.sv
module test_mdec_bank;
  localparam int CLK_PERIOD = 10;
  localparam int VC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_e = 1'b0, wr_s = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_e, rd_s;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdec_bank #(.NUM_DEC(4), .TGT_CNT(8), .SWITCH(0), .VALIDATE_CYCLES(VC),
              .IL_LOW(1), .IL_HIGH(0), .ADDR_W(8)) i_mdec_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_e), .addr(addr), .wdata(wdata), .rdata(rd_e));

  mdec_bank #(.NUM_DEC(4), .TGT_CNT(4), .SWITCH(1), .VALIDATE_CYCLES(VC),
              .IL_LOW(0), .IL_HIGH(1), .ADDR_W(8)) i_mdec_bank_sw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_s), .addr(addr), .wdata(wdata), .rdata(rd_s));

  function automatic logic [7:0] adr(input int dec, input int f);
    return 8'(8 * (dec + 1) + f);
  endfunction

  function automatic int ways_of(input int code);
    if (code < 4) return 1 << code;
    if (code == 8) return 3;
    if (code == 9) return 6;
    return 0;
  endfunction

  function automatic logic [31:0] ctl(input int gran, input int code, input bit typ,
                                      input bit lock, input bit err, input bit dn, input bit cm);
    return (32'(gran) << 12) | (32'(code) << 8) | (32'(typ) << 4) | (32'(lock) << 3)
         | (32'(err) << 2) | (32'(dn) << 1) | 32'(cm);
  endfunction

  task automatic wr(input bit sw, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sw) wr_s = 1'b1; else wr_e = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_s = 1'b0; wr_e = 1'b0;
  endtask

  task automatic rd(input bit sw, input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = sw ? rd_s : rd_e;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input bit sw, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(sw, a, v);
    chk(tag, v, exp);
  endtask

  task automatic settle();
    repeat (VC) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset and capability
    chk_rd("R1 cap ep", 0, 8'd0, 32'h0001_0804);
    chk_rd("R1 cap sw", 1, 8'd0, 32'h0002_0404);
    for (int d = 0; d < 4; d++)
      for (int f = 0; f < 8; f++) chk_rd("R1 zero", 0, adr(d, f), 32'h0);

    // R2 readback of halves on decoder 1
    wr(0, adr(1, 0), 32'hdead_0000); wr(0, adr(1, 1), 32'h0000_00a5);
    wr(0, adr(1, 2), 32'h0000_0040); wr(0, adr(1, 5), 32'h1357_9bdf);
    wr(0, adr(1, 6), 32'h2468_ace0);
    chk_rd("R2 base lo", 0, adr(1, 0), 32'hdead_0000);
    chk_rd("R2 base hi", 0, adr(1, 1), 32'h0000_00a5);
    chk_rd("R2 size lo", 0, adr(1, 2), 32'h0000_0040);
    chk_rd("R2 skip lo", 0, adr(1, 5), 32'h1357_9bdf);
    chk_rd("R2 skip hi", 0, adr(1, 6), 32'h2468_ace0);
    wr(1, adr(0, 5), 32'h0403_0201);
    chk_rd("R2 target list", 1, adr(0, 5), 32'h0403_0201);

    // R3 status bits are read-only
    wr(0, adr(1, 4), ctl(2, 1, 1, 0, 1, 1, 0));
    chk_rd("R3 ctrl", 0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 0));

    // R4 out of order commit on decoder 1
    wr(0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 1));
    settle();
    chk_rd("R4 out of order", 0, adr(1, 4), ctl(2, 1, 1, 0, 1, 0, 1));
    // R11 clearing commit clears the error
    wr(0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 0));
    chk_rd("R11 err clear", 0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 0));

    // R6, R7, R8 plus random trials on decoder 0
    for (int t = 0; t < 40; t++) begin
      int sz, code, w;
      bit ok;
      logic [31:0] v;
      sz   = (t == 0) ? 0 : int'($urandom_range(0, 96));
      code = (t == 1) ? 4 : int'($urandom_range(0, 15));
      w = ways_of(code);
      ok = (sz != 0) && (w != 0) && ((sz % (w == 0 ? 1 : w)) == 0);
      wr(0, adr(0, 2), 32'(sz));
      wr(0, adr(0, 4), ctl(0, code, 0, 0, 0, 0, 1));
      settle();
      rd(0, adr(0, 4), v);
      chk(ok ? "R7 R8 accept" : "R6 R7 R8 reject", v, ctl(0, code, 0, 0, !ok, ok, 1));
      wr(0, adr(0, 4), ctl(0, code, 0, 0, 0, 0, 0));
      chk_rd("R10 R11 clear", 0, adr(0, 4), ctl(0, code, 0, 0, 0, 0, 0));
    end

    // R8 directed: 3 ways with 256 and 192
    wr(0, adr(0, 2), 32'd256);
    wr(0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 1));
    settle();
    chk_rd("R8 indivisible", 0, adr(0, 4), ctl(0, 8, 0, 0, 1, 0, 1));
    wr(0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 0));
    wr(0, adr(0, 2), 32'd192);

    // R5 timing window
    wr(0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 1));
    repeat (VC - 1) @(negedge clk);
    chk_rd("R5 still pending", 0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 1));
    @(negedge clk);
    chk_rd("R5 result due", 0, adr(0, 4), ctl(0, 8, 0, 0, 0, 1, 1));

    // R9 frozen while committed
    wr(0, adr(0, 0), 32'h1111_2222);
    wr(0, adr(0, 2), 32'd64);
    wr(0, adr(0, 5), 32'h0000_0fff);
    wr(0, adr(0, 4), ctl(5, 1, 1, 0, 0, 0, 1));
    chk_rd("R9 base held", 0, adr(0, 0), 32'h0);
    chk_rd("R9 size held", 0, adr(0, 2), 32'd192);
    chk_rd("R9 skip held", 0, adr(0, 5), 32'h0);
    chk_rd("R9 ctrl held", 0, adr(0, 4), ctl(0, 8, 0, 0, 0, 1, 1));

    // R4 in order commit of decoder 1 now accepted
    wr(0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 1));
    settle();
    chk_rd("R4 in order", 0, adr(1, 4), ctl(2, 1, 1, 0, 0, 1, 1));

    // R10 un-commit order
    wr(0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 0));
    chk_rd("R10 lower kept", 0, adr(0, 4), ctl(0, 8, 0, 0, 0, 1, 1));
    wr(0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 0));
    chk_rd("R10 top dropped", 0, adr(1, 4), ctl(2, 1, 1, 0, 0, 0, 0));
    wr(0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 0));
    chk_rd("R10 lower dropped", 0, adr(0, 4), ctl(0, 8, 0, 0, 0, 0, 0));

    // R7 switch flavour target limit (4 targets)
    wr(1, adr(0, 2), 32'd256);
    wr(1, adr(0, 4), ctl(0, 3, 1, 0, 0, 0, 1));
    settle();
    chk_rd("R7 ways over targets", 1, adr(0, 4), ctl(0, 3, 1, 0, 1, 0, 1));
    wr(1, adr(0, 4), ctl(0, 2, 1, 0, 0, 0, 0));
    wr(1, adr(0, 4), ctl(0, 2, 1, 0, 0, 0, 1));
    settle();
    chk_rd("R7 ways within targets", 1, adr(0, 4), ctl(0, 2, 1, 0, 0, 1, 1));

    // R12 lock blocks un-commit
    wr(0, adr(0, 2), 32'd64);
    wr(0, adr(0, 4), ctl(0, 0, 1, 1, 0, 0, 1));
    settle();
    chk_rd("R12 locked commit", 0, adr(0, 4), ctl(0, 0, 1, 1, 0, 1, 1));
    wr(0, adr(0, 4), 32'h0);
    chk_rd("R12 un-commit blocked", 0, adr(0, 4), ctl(0, 0, 1, 1, 0, 1, 1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule